// File: doc/BRIEF.md
# Cascaded Clock-Enable Divider Bank

This block derives four slow clock-enable streams from three free-running reference tick inputs. Each of the four channels picks one reference, divides its ticks by two 6-bit divisors in cascade, and emits a single-cycle pulse on its `outTick` bit once per divided period. Everything runs on one system clock. The reference inputs are enables that mark reference edges, and the outputs are enables for downstream logic. Neither is a real clock.

Software sets up each channel through a small register bus. Every channel has a configuration word holding the source code and the two divisors, plus a halt word. A full-word write replaces the whole configuration, so changing one field means a read-modify-write. While a channel runs, a new configuration is held back until the current output period ends. A halted channel clears its counters, so after release it always delivers a complete period.

Top module: `clkdiv_bank`

## Requirements
- R1: Channel n (0..3) has its configuration word at byte address 0x170 + 0x10·n and its halt word at 0x178 + 0x10·n. Any other address reads as zero, and a write to it changes no register.
- R2: Configuration word fields are source code in bits 5:4, first divisor in bits 13:8 and second divisor in bits 25:20. A write replaces all three fields at once, and every other bit reads back as zero.
- R3: After reset every configuration word reads 0x00100100 (both divisors 1, source 0), every halt word reads 0, and `outTick` is all zero.
- R4: Source codes 0 and 1 both count ticks of `refTick[0]`, code 2 counts `refTick[1]` and code 3 counts `refTick[2]`. Ticks on the other two references have no effect on the channel.
- R5: A running channel raises its `outTick` bit for exactly one cycle. This happens in the cycle after it samples the (D0·D1)-th selected reference tick since its last pulse or release.
- R6: A divisor field holding zero divides by one.
- R7: Bit 0 of the halt word set to 1 stops the channel: no pulses, counters cleared. Clearing it restarts the channel, and the first pulse follows a full D0·D1 ticks. The other halt word bits read as zero.
- R8: A configuration written while a channel runs takes effect only after that channel's next pulse. A configuration written while the channel is halted is in force from release.
- R9: Each channel counts and pulses independently of the others, even when several share one reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrite | input | 1 | Write strobe for one full word |
| busAddr | input | 12 | Byte address for reads and writes |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| refTick | input | 3 | One-cycle edge markers of the three references |
| outTick | output | 4 | Per-channel divided clock-enable pulses |

## Verification
The hardest state to reach from the ports is a channel part-way through a period when new divisors arrive. The old period must complete before the new one starts. The stimulus gets there by releasing a channel, feeding it only part of a period of ticks, rewriting its divisors, and then counting the ticks to each of the next two pulses. A similar mid-period halt followed by release shows that leftover count is discarded. Source aliasing is exposed by ticking only the expected reference, so a wrong selection never pulses.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int NUM_CH    = 4;
  localparam int NUM_REF   = 3;
  localparam int DIV_W     = 6;
  localparam int SRC_W     = 2;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int REF_IDX_W = $clog2(NUM_REF);

  localparam int SRC_LSB  = 4;
  localparam int DIV0_LSB = 8;
  localparam int DIV1_LSB = 20;

  localparam int CFG_BASE  = 'h170;
  localparam int CH_STRIDE = 'h10;
  localparam int HALT_OFF  = 'h8;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [DIV_W-1:0] div0;
    logic [DIV_W-1:0] div1;
    logic             halt;
  } chanCfg_t;

  function automatic logic [ADDR_W-1:0] cfgAddr(input int ch);
    return ADDR_W'(CFG_BASE + ch * CH_STRIDE);
  endfunction

  function automatic logic [ADDR_W-1:0] haltAddr(input int ch);
    return ADDR_W'(CFG_BASE + ch * CH_STRIDE + HALT_OFF);
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  output chanCfg_t [NUM_CH-1:0] cfgVec
);
  logic unusedWdataBits;
  assign unusedWdataBits = ^{busWdata[DATA_W-1:DIV1_LSB+DIV_W],
                             busWdata[DIV1_LSB-1:DIV0_LSB+DIV_W],
                             busWdata[DIV0_LSB-1:SRC_LSB+SRC_W],
                             busWdata[SRC_LSB-1:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        cfgVec[c].src  <= '0;
        cfgVec[c].div0 <= DIV_W'(1);
        cfgVec[c].div1 <= DIV_W'(1);
        cfgVec[c].halt <= 1'b0;
      end
    end else if (busWrite) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (busAddr == cfgAddr(c)) begin
          cfgVec[c].src  <= busWdata[SRC_LSB+:SRC_W];
          cfgVec[c].div0 <= busWdata[DIV0_LSB+:DIV_W];
          cfgVec[c].div1 <= busWdata[DIV1_LSB+:DIV_W];
        end
        if (busAddr == haltAddr(c)) begin
          cfgVec[c].halt <= busWdata[0];
        end
      end
    end
  end

  always_comb begin
    busRdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (busAddr == cfgAddr(c)) begin
        busRdata[SRC_LSB+:SRC_W]   = cfgVec[c].src;
        busRdata[DIV0_LSB+:DIV_W]  = cfgVec[c].div0;
        busRdata[DIV1_LSB+:DIV_W]  = cfgVec[c].div1;
      end
      if (busAddr == haltAddr(c)) begin
        busRdata[0] = cfgVec[c].halt;
      end
    end
  end
endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_REF-1:0]    refTick,
  input  chanCfg_t [NUM_CH-1:0] cfgVec,
  output logic [NUM_CH-1:0]     outTick
);
  function automatic logic [DIV_W-1:0] lastCount(input logic [DIV_W-1:0] d);
    return (d == '0) ? '0 : d - 1'b1;
  endfunction

  function automatic logic [REF_IDX_W-1:0] refIndex(input logic [SRC_W-1:0] s);
    if (!s[SRC_W-1]) return '0;
    return REF_IDX_W'(s) - 1'b1;
  endfunction

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [SRC_W-1:0] actSrc;
    logic [DIV_W-1:0] actDiv0, actDiv1;
    logic [DIV_W-1:0] cnt0, cnt1;
    logic             tickSel, stage0End, periodEnd;

    assign tickSel   = refTick[refIndex(actSrc)];
    assign stage0End = tickSel && (cnt0 == lastCount(actDiv0));
    assign periodEnd = stage0End && (cnt1 == lastCount(actDiv1));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        actSrc     <= '0;
        actDiv0    <= DIV_W'(1);
        actDiv1    <= DIV_W'(1);
        cnt0       <= '0;
        cnt1       <= '0;
        outTick[c] <= 1'b0;
      end else if (cfgVec[c].halt) begin
        actSrc     <= cfgVec[c].src;
        actDiv0    <= cfgVec[c].div0;
        actDiv1    <= cfgVec[c].div1;
        cnt0       <= '0;
        cnt1       <= '0;
        outTick[c] <= 1'b0;
      end else begin
        outTick[c] <= periodEnd;
        if (tickSel)   cnt0 <= stage0End ? '0 : cnt0 + 1'b1;
        if (stage0End) cnt1 <= periodEnd ? '0 : cnt1 + 1'b1;
        if (periodEnd) begin
          actSrc  <= cfgVec[c].src;
          actDiv0 <= cfgVec[c].div0;
          actDiv1 <= cfgVec[c].div1;
        end
      end
    end
  end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [NUM_REF-1:0]   refTick,
  output logic [NUM_CH-1:0]    outTick
);
  chanCfg_t [NUM_CH-1:0] cfgVec;

  clkdiv_regs i_regs (
    .clk      (clk),
    .rstN     (rstN),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .cfgVec   (cfgVec)
  );

  clkdiv_datapath i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .refTick (refTick),
    .cfgVec  (cfgVec),
    .outTick (outTick)
  );
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk
  import clkdiv_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  busWrite,
  input logic [DATA_W-1:0]     busRdata,
  input logic [NUM_REF-1:0]    refTick,
  input logic [NUM_CH-1:0]     outTick,
  input chanCfg_t [NUM_CH-1:0] cfgVec
);
  localparam logic [DATA_W-1:0] READ_MASK = 32'h03F0_3F31;

  // R1
  no_write_regs_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWrite |=> $stable(cfgVec));

  // R2
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdata & ~READ_MASK) == '0);

  // R4
  pulse_needs_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outTick != '0) |-> ($past(refTick) != '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R7
    halted_no_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
      cfgVec[c].halt |=> !outTick[c]);
  end
endmodule

bind clkdiv_bank clkdiv_bank_chk i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWrite (busWrite),
  .busRdata (busRdata),
  .refTick  (refTick),
  .outTick  (outTick),
  .cfgVec   (cfgVec)
);

// File: tb/test_clkdiv_bank.sv
module test_clkdiv_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [2:0]  refTick = '0;
  logic [3:0]  outTick;

  int nChecks = 0;
  int nFail   = 0;
  int pulseCnt [4];
  int firstAt  [4];

  always #5 clk = ~clk;

  clkdiv_bank i_clkdiv_bank (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .refTick(refTick), .outTick(outTick)
  );

  // {chan, src, div0, div1, ticks per period, reference index, pad}
  localparam logic [31:0] VEC [0:7] = '{
    {2'd0, 2'd0, 6'd3,  6'd2,  12'd6,    2'd0, 2'd0},
    {2'd1, 2'd1, 6'd5,  6'd1,  12'd5,    2'd0, 2'd0},
    {2'd2, 2'd2, 6'd0,  6'd4,  12'd4,    2'd1, 2'd0},
    {2'd3, 2'd3, 6'd7,  6'd0,  12'd7,    2'd2, 2'd0},
    {2'd0, 2'd3, 6'd0,  6'd0,  12'd1,    2'd2, 2'd0},
    {2'd1, 2'd2, 6'd63, 6'd2,  12'd126,  2'd1, 2'd0},
    {2'd2, 2'd0, 6'd63, 6'd63, 12'd3969, 2'd0, 2'd0},
    {2'd3, 2'd1, 6'd2,  6'd9,  12'd18,   2'd0, 2'd0}
  };

  function automatic logic [11:0] cfgA(input int c);  return 12'(32'h170 + 16 * c); endfunction
  function automatic logic [11:0] haltA(input int c); return 12'(32'h178 + 16 * c); endfunction
  function automatic logic [31:0] cfgWord(input int src, input int d0, input int d1);
    return (32'(d1) << 20) | (32'(d0) << 8) | (32'(src) << 4);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic tickRef(input int r, input int n);
    for (int c = 0; c < 4; c++) begin pulseCnt[c] = 0; firstAt[c] = 0; end
    for (int k = 1; k <= n; k++) begin
      @(negedge clk); refTick[r] = 1'b1;
      @(negedge clk); refTick[r] = 1'b0;
      for (int c = 0; c < 4; c++) begin
        if (outTick[c]) begin
          pulseCnt[c]++;
          if (firstAt[c] == 0) firstAt[c] = k;
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R3 reset state
    chk("R3 outTick after reset", 32'(outTick), 32'h0);
    for (int c = 0; c < 4; c++) begin
      busRd(cfgA(c), rd);  chk("R3 config word reset", rd, 32'h0010_0100);
      busRd(haltA(c), rd); chk("R3 halt word reset", rd, 32'h0);
    end
    // R3 R5 default divide-by-one on reference 0 pulses every channel
    tickRef(0, 1);
    chk("R5 default config pulses all channels", 32'(pulseCnt[0] + pulseCnt[1] + pulseCnt[2] + pulseCnt[3]), 32'd4);

    // vector table: R2 R4 R5 R6
    for (int v = 0; v < 8; v++) begin
      int ch, src, d0, d1, n, r;
      ch = int'(VEC[v][31:30]); src = int'(VEC[v][29:28]);
      d0 = int'(VEC[v][27:22]); d1 = int'(VEC[v][21:16]);
      n  = int'(VEC[v][15:4]);  r   = int'(VEC[v][3:2]);
      busWr(cfgA(ch), cfgWord(src, d0, d1) | 32'hFC0F_C0CF);
      busRd(cfgA(ch), rd);
      chk("R2 config readback masks unused bits", rd, cfgWord(src, d0, d1));
      busWr(haltA(ch), 32'h1);
      busWr(haltA(ch), 32'h0);
      tickRef(r, n);
      chk("R5 R6 ticks to first pulse", 32'(firstAt[ch]), 32'(n));
      chk("R4 pulse count on selected reference", 32'(pulseCnt[ch]), 32'd1);
      tickRef(r, n);
      chk("R5 second period length", 32'(firstAt[ch]), 32'(n));
    end

    // R4 unselected references have no effect: ch3 on code 3 (refTick[2])
    busWr(cfgA(3), cfgWord(3, 1, 1));
    busWr(haltA(3), 32'h1);
    busWr(haltA(3), 32'h0);
    tickRef(0, 3);
    tickRef(1, 3);
    chk("R4 other references ignored", 32'(pulseCnt[3]), 32'd0);

    // R8 divisor change mid-period waits for the boundary
    busWr(cfgA(0), cfgWord(0, 4, 1));
    busWr(haltA(0), 32'h1);
    busWr(haltA(0), 32'h0);
    tickRef(0, 2);
    chk("R8 no pulse mid-period", 32'(pulseCnt[0]), 32'd0);
    busWr(cfgA(0), cfgWord(0, 2, 1));
    tickRef(0, 2);
    chk("R8 old period completes", 32'(firstAt[0]), 32'd2);
    tickRef(0, 2);
    chk("R8 new period after boundary", 32'(firstAt[0]), 32'd2);

    // R7 halt discards partial count
    tickRef(0, 1);
    busWr(haltA(0), 32'h1);
    tickRef(0, 5);
    chk("R7 halted channel silent", 32'(pulseCnt[0]), 32'd0);
    busWr(haltA(0), 32'h0);
    tickRef(0, 2);
    chk("R7 full period after release", 32'(firstAt[0]), 32'd2);
    busWr(haltA(0), 32'hFFFF_FFFE);
    busRd(haltA(0), rd); chk("R7 halt word only bit 0", rd, 32'h0);
    busWr(haltA(0), 32'hFFFF_FFFF);
    busRd(haltA(0), rd); chk("R7 halt word set reads 1", rd, 32'h1);
    busWr(haltA(0), 32'h0);

    // R1 unmapped addresses
    busWr(12'h174, 32'hFFFF_FFFF);
    busWr(12'h17C, 32'hFFFF_FFFF);
    busWr(12'h1B0, 32'hFFFF_FFFF);
    busRd(cfgA(0), rd);  chk("R1 config untouched by stray write", rd, cfgWord(0, 2, 1));
    busRd(haltA(0), rd); chk("R1 halt untouched by stray write", rd, 32'h0);
    busRd(cfgA(3), rd);  chk("R1 ch3 config untouched", rd, cfgWord(3, 1, 1));
    busRd(12'h174, rd);  chk("R1 unmapped reads zero", rd, 32'h0);
    busRd(12'h1B0, rd);  chk("R1 past last channel reads zero", rd, 32'h0);

    // R9 two channels on one reference count independently
    busWr(cfgA(0), cfgWord(1, 2, 1));
    busWr(cfgA(1), cfgWord(0, 1, 3));
    busWr(haltA(0), 32'h1); busWr(haltA(1), 32'h1);
    busWr(haltA(0), 32'h0); busWr(haltA(1), 32'h0);
    tickRef(0, 6);
    chk("R9 ch0 pulses", 32'(pulseCnt[0]), 32'd3);
    chk("R9 ch1 pulses", 32'(pulseCnt[1]), 32'd2);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule